// File: doc/BRIEF.md
# Internal Data Memory Router

This block sits between a CPU core's operand path and its on-chip data storage. It holds the 256-byte internal RAM and decides, for every access, whether the byte comes from that RAM or from the special-function-register (SFR) port. Addresses in the upper half can mean either upper RAM or an SFR. The addressing mode of the access settles which one is meant. Register-mode accesses are moved into one of four eight-byte banks by a two-bit bank selector. Bit-mode accesses are turned into a byte access plus a bit position. A bit write is built as a read-modify-write of the containing byte within the same cycle.

The core presents one access per cycle with `req` high. Writes take effect at the clock edge that samples them. Read results appear on `rdData` with `rdValid` one cycle later. The SFR registers live outside this block. They answer through a combinational read port and report through `sfrHit` whether the presented address is implemented. Bytes read from a missing SFR come back as a fixed filler value, and writes to a missing SFR are dropped.

Top module: `idm_router`

## Requirements
- R1: Mode code 2'b00 (direct): an address below 0x80 reads or writes the RAM byte at that address. An address of 0x80 or above goes to the SFR port with `sfrSel` high and `sfrAddr` equal to the address, and RAM is left unchanged.
- R2: Mode code 2'b01 (indirect): every address, 0x80..0xFF included, reads or writes the RAM byte at that address. `sfrSel`, `sfrRdEn` and `sfrWrEn` stay low, so upper RAM and the SFR at the same address are independent.
- R3: Mode code 2'b10 (register): the RAM byte at `bankSel`*8 + `addr[2:0]` is accessed. `addr[7:3]` has no effect.
- R4: Mode code 2'b11 (bit) with `addr` below 0x80: the byte is RAM 0x20 + `addr[6:3]` and the bit position is `addr[2:0]`. A read returns that bit in `rdData[0]` with bits 7..1 zero. A write replaces only that bit with `bitVal`.
- R5: Bit mode with `addr` of 0x80 or above: `sfrAddr` is `addr` with bits 2..0 cleared. A read returns bit `addr[2:0]` of `sfrRdData`. A write drives `sfrWrData` as `sfrRdData` with that bit replaced by `bitVal`.
- R6: When an SFR access has `sfrHit` low, a read returns the filler value (0xFF by default), or its selected bit in bit mode, and a write keeps `sfrWrEn` low.
- R7: A request with `wrEn` low gives `rdValid` high and the result on `rdData` in the next cycle. Any other cycle leaves `rdValid` low in the next cycle. A RAM write is visible to a read in the following cycle.
- R8: After reset, `rdValid` and `rdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request this cycle |
| mode | input | 2 | 00 direct, 01 indirect, 10 register, 11 bit |
| addr | input | 8 | Byte, register or bit address |
| wrEn | input | 1 | Access is a write |
| wrData | input | 8 | Byte write data |
| bitVal | input | 1 | Value for a bit write |
| bankSel | input | 2 | Register bank selector |
| rdData | output | 8 | Read result, one cycle after the request |
| rdValid | output | 1 | rdData holds a fresh result |
| sfrSel | output | 1 | Access targets the SFR port (low: RAM) |
| sfrAddr | output | 8 | SFR address presented to the register file |
| sfrRdEn | output | 1 | SFR read strobe |
| sfrWrEn | output | 1 | SFR write strobe |
| sfrWrData | output | 8 | SFR write byte (merged for bit writes) |
| sfrRdData | input | 8 | Combinational SFR read data |
| sfrHit | input | 1 | Presented SFR address is implemented |

## Verification
The hardest situation to reach is an upper-half address that holds different contents in RAM and in the SFR file. Only then does a wrong choice of target show up at the read port. The stimulus first fills all of RAM through indirect writes and the SFR file with an unrelated pattern. It then mixes random accesses across all four modes with directed pairs that write 0x90 through one mode and read it through the other. Bit writes into 0x20..0x2F and into SFRs are followed by byte reads, so that a change to any neighbouring bit is caught.

// File: rtl/idm_pkg.sv
package idm_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_REGISTER = 2'b10,
    MODE_BIT      = 2'b11
  } accMode_e;

  // strobes from the decode control to the datapath
  typedef struct packed {
    logic ramWe;     // write RAM at the decoded byte
    logic sfrWe;     // write the SFR port
    logic sfrRe;     // read the SFR port
    logic sfrTgt;    // SFR port is the source/target
    logic bitOp;     // single-bit access
    logic useFill;   // missing SFR: substitute filler
    logic capture;   // load the read result register
  } idmStrobe_t;

endpackage

// File: rtl/idm_ctrl.sv
module idm_ctrl
  import idm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic              req,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              sfrHit,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [$clog2(DATA_W)-1:0] bitPos,
  output idmStrobe_t        strobe
);

  localparam int BPOS_W = $clog2(DATA_W);
  localparam int IDX_W  = ADDR_W - 1 - BPOS_W;
  localparam logic [ADDR_W-1:0] BIT_BASE = ADDR_W'(1 << (BANK_W + REG_W));

  logic isHigh;
  logic sfrTgt;
  accMode_e accMode;

  assign isHigh  = addr[ADDR_W-1];
  assign accMode = accMode_e'(mode);
  assign bitPos  = addr[BPOS_W-1:0];

  always_comb begin
    sfrTgt   = 1'b0;
    byteAddr = addr;
    unique case (accMode)
      MODE_DIRECT: begin
        sfrTgt   = isHigh;
        byteAddr = addr;
      end
      MODE_INDIRECT: begin
        sfrTgt   = 1'b0;
        byteAddr = addr;
      end
      MODE_REGISTER: begin
        sfrTgt   = 1'b0;
        byteAddr = {{(ADDR_W-BANK_W-REG_W){1'b0}}, bankSel, addr[REG_W-1:0]};
      end
      MODE_BIT: begin
        sfrTgt = isHigh;
        if (isHigh)
          byteAddr = {addr[ADDR_W-1:BPOS_W], {BPOS_W{1'b0}}};
        else
          byteAddr = BIT_BASE + {{(BPOS_W+1){1'b0}}, addr[BPOS_W+IDX_W-1:BPOS_W]};
      end
      default: begin
        sfrTgt   = 1'b0;
        byteAddr = addr;
      end
    endcase
  end

  always_comb begin
    strobe.sfrTgt  = req & sfrTgt;
    strobe.bitOp   = (accMode == MODE_BIT);
    strobe.ramWe   = req & wrEn & ~sfrTgt;
    strobe.sfrWe   = req & wrEn & sfrTgt & sfrHit;
    strobe.sfrRe   = req & sfrTgt;
    strobe.useFill = sfrTgt & ~sfrHit;
    strobe.capture = req & ~wrEn;
  end

endmodule

// File: rtl/idm_datapath.sv
module idm_datapath
  import idm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  idmStrobe_t        strobe,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [$clog2(DATA_W)-1:0] bitPos,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitVal,
  input  logic [DATA_W-1:0] sfrRdData,
  output logic [DATA_W-1:0] wrByte,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramRd;
  logic [DATA_W-1:0] srcByte;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdNext;

  assign ramRd = mem[byteAddr];

  always_comb begin
    if (strobe.useFill)     srcByte = DATA_W'(FILL);
    else if (strobe.sfrTgt) srcByte = sfrRdData;
    else                    srcByte = ramRd;
  end

  // per-lane bit insertion for read-modify-write
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign merged[i] = (bitPos == i[$clog2(DATA_W)-1:0]) ? bitVal : srcByte[i];
  end

  assign wrByte = strobe.bitOp ? merged : wrData;
  assign rdNext = strobe.bitOp ? {{(DATA_W-1){1'b0}}, srcByte[bitPos]} : srcByte;

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[byteAddr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/idm_router.sv
module idm_router
  import idm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitVal,
  input  logic [BANK_W-1:0] bankSel,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              sfrSel,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic              sfrRdEn,
  output logic              sfrWrEn,
  output logic [DATA_W-1:0] sfrWrData,
  input  logic [DATA_W-1:0] sfrRdData,
  input  logic              sfrHit
);

  idmStrobe_t        strobe;
  logic [ADDR_W-1:0] byteAddr;
  logic [$clog2(DATA_W)-1:0] bitPos;
  logic [DATA_W-1:0] wrByte;

  idm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .REG_W(REG_W)
  ) u_ctrl (
    .req(req), .mode(mode), .addr(addr), .wrEn(wrEn), .bankSel(bankSel),
    .sfrHit(sfrHit), .byteAddr(byteAddr), .bitPos(bitPos), .strobe(strobe)
  );

  idm_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL(FILL)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .byteAddr(byteAddr), .bitPos(bitPos),
    .wrData(wrData), .bitVal(bitVal), .sfrRdData(sfrRdData), .wrByte(wrByte),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign sfrSel    = strobe.sfrTgt;
  assign sfrAddr   = byteAddr;
  assign sfrRdEn   = strobe.sfrRe;
  assign sfrWrEn   = strobe.sfrWe;
  assign sfrWrData = wrByte;

endmodule

// File: rtl/idm_checker.sv
module idm_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [7:0] FILL = 8'hFF
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              sfrSel,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic              sfrRdEn,
  input logic              sfrWrEn,
  input logic              sfrHit
);

  AST_DIRECT_HIGH_SFR: assert property (@(posedge clk) disable iff (rst)
    req && mode == 2'b00 && addr[ADDR_W-1] |-> sfrSel && sfrAddr == addr); // R1

  AST_INDIRECT_RAM: assert property (@(posedge clk) disable iff (rst)
    req && mode == 2'b01 |-> !sfrSel && !sfrRdEn && !sfrWrEn); // R2

  AST_REGISTER_RAM: assert property (@(posedge clk) disable iff (rst)
    req && mode == 2'b10 |-> !sfrSel && !sfrWrEn); // R3

  AST_BIT_SFR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    req && mode == 2'b11 && addr[ADDR_W-1] |-> sfrSel && sfrAddr[2:0] == 3'b000
      && sfrAddr[ADDR_W-1:3] == addr[ADDR_W-1:3]); // R5

  AST_NO_MISSING_WRITE: assert property (@(posedge clk) disable iff (rst)
    sfrWrEn |-> sfrHit); // R6

  AST_FILL_READ: assert property (@(posedge clk) disable iff (rst)
    req && !wrEn && mode == 2'b00 && sfrSel && !sfrHit |=> rdData == DATA_W'(FILL)); // R6

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    req && !wrEn |=> rdValid); // R7

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(req && !wrEn) |=> !rdValid); // R7

endmodule

bind idm_router idm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL(FILL)) u_chk (
  .clk(clk), .rst(rst), .req(req), .mode(mode), .addr(addr), .wrEn(wrEn),
  .rdData(rdData), .rdValid(rdValid), .sfrSel(sfrSel), .sfrAddr(sfrAddr),
  .sfrRdEn(sfrRdEn), .sfrWrEn(sfrWrEn), .sfrHit(sfrHit)
);

// File: tb/idm_router_tb.sv
module idm_router_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       bitVal = 1'b0;
  logic [1:0] bankSel = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       sfrSel;
  logic [7:0] sfrAddr;
  logic       sfrRdEn;
  logic       sfrWrEn;
  logic [7:0] sfrWrData;
  logic [7:0] sfrRdData;
  logic       sfrHit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] envSfr [128];
  logic [7:0] expSfr [128];
  logic [7:0] expRam [256];

  always #4 clk = ~clk;

  idm_router u_dut (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .bitVal(bitVal), .bankSel(bankSel), .rdData(rdData),
    .rdValid(rdValid), .sfrSel(sfrSel), .sfrAddr(sfrAddr), .sfrRdEn(sfrRdEn),
    .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .sfrHit(sfrHit)
  );

  // SFR file environment: 0xE0..0xFF are missing
  assign sfrRdData = envSfr[sfrAddr[6:0]];
  assign sfrHit    = (sfrAddr[6:5] != 2'b11);
  always @(posedge clk) if (sfrWrEn) envSfr[sfrAddr[6:0]] <= sfrWrData;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic bit expIsSfr(logic [1:0] m, logic [7:0] a);
    return (m == 2'b00 || m == 2'b11) && a[7];
  endfunction

  function automatic logic [7:0] expByteAddr(logic [1:0] m, logic [7:0] a, logic [1:0] b);
    case (m)
      2'b10:   return {3'b000, b, a[2:0]};
      2'b11:   return a[7] ? {a[7:3], 3'b000} : 8'h20 + {4'h0, a[6:3]};
      default: return a;
    endcase
  endfunction

  function automatic string reqTag(logic [1:0] m, logic [7:0] a);
    if (m == 2'b00) return a[7] ? "R1/R6" : "R1";
    if (m == 2'b01) return "R2";
    if (m == 2'b10) return "R3";
    return a[7] ? "R5" : "R4";
  endfunction

  task automatic op(logic [1:0] m, logic [7:0] a, logic w, logic [7:0] d,
                    logic bv, logic [1:0] b);
    logic [7:0] ba;
    logic [7:0] src;
    logic [7:0] expRd;
    logic [7:0] newByte;
    bit sfr;
    bit hit;
    sfr = expIsSfr(m, a);
    ba  = expByteAddr(m, a, b);
    hit = !(sfr && ba[6:5] == 2'b11);
    src = sfr ? (hit ? expSfr[ba[6:0]] : 8'hFF) : expRam[ba];
    expRd = (m == 2'b11) ? {7'b0, src[a[2:0]]} : src;
    newByte = d;
    if (m == 2'b11) begin
      newByte = src;
      newByte[a[2:0]] = bv;
    end
    @(negedge clk);
    req = 1'b1; mode = m; addr = a; wrEn = w; wrData = d; bitVal = bv; bankSel = b;
    #1;
    chk({reqTag(m, a), " sfrSel"}, {7'b0, sfrSel}, {7'b0, sfr});
    if (sfr) chk({reqTag(m, a), " sfrAddr"}, sfrAddr, ba);
    if (w) chk({reqTag(m, a), " sfrWrEn"}, {7'b0, sfrWrEn}, {7'b0, sfr && hit});
    if (w && sfr && hit) chk({reqTag(m, a), " sfrWrData"}, sfrWrData, newByte);
    @(posedge clk);
    #1;
    chk("R7 rdValid", {7'b0, rdValid}, {7'b0, !w});
    if (!w) chk({reqTag(m, a), " rdData"}, rdData, expRd);
    if (w) begin
      if (!sfr) expRam[ba] = newByte;
      else if (hit) expSfr[ba[6:0]] = newByte;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; wrEn = 1'b0;
    @(posedge clk);
    #1;
    chk("R7 idle rdValid", {7'b0, rdValid}, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) begin
      envSfr[i] = 8'($urandom);
      expSfr[i] = envSfr[i];
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset rdValid", {7'b0, rdValid}, 8'h00);
    chk("R8 reset rdData", rdData, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // fill all RAM through indirect writes
    for (int i = 0; i < 256; i++) op(2'b01, 8'(i), 1'b1, 8'(i * 7 + 3), 1'b0, 2'b00);

    // R1/R2: same upper address through both modes
    op(2'b00, 8'h90, 1'b1, 8'hA5, 1'b0, 2'b00);
    op(2'b01, 8'h90, 1'b1, 8'h3C, 1'b0, 2'b00);
    op(2'b00, 8'h90, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b01, 8'h90, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b00, 8'h45, 1'b1, 8'h12, 1'b0, 2'b00);
    op(2'b01, 8'h45, 1'b0, 8'h00, 1'b0, 2'b00);

    // R3: bank 3 register 5 lands on 0x1D; upper addr bits ignored
    op(2'b10, 8'hF5, 1'b1, 8'h6E, 1'b0, 2'b11);
    op(2'b01, 8'h1D, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b10, 8'h02, 1'b0, 8'h00, 1'b0, 2'b01);

    // R4: bit 0x7F is byte 0x2F bit 7
    op(2'b11, 8'h7F, 1'b1, 8'h00, 1'b1, 2'b00);
    op(2'b01, 8'h2F, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b11, 8'h7F, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b11, 8'h00, 1'b1, 8'h00, 1'b0, 2'b00);
    op(2'b01, 8'h20, 1'b0, 8'h00, 1'b0, 2'b00);

    // R5: bit 0x8B is SFR 0x88 bit 3
    op(2'b11, 8'h8B, 1'b1, 8'h00, 1'b1, 2'b00);
    op(2'b00, 8'h88, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b11, 8'h8B, 1'b1, 8'h00, 1'b0, 2'b00);
    op(2'b00, 8'h88, 1'b0, 8'h00, 1'b0, 2'b00);

    // R6: missing SFR 0xE5
    op(2'b00, 8'hE5, 1'b1, 8'h00, 1'b0, 2'b00);
    op(2'b00, 8'hE5, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b11, 8'hF2, 1'b0, 8'h00, 1'b0, 2'b00);
    op(2'b01, 8'hE5, 1'b0, 8'h00, 1'b0, 2'b00);

    // R7: write then read back-to-back, then an idle cycle
    op(2'b01, 8'hC3, 1'b1, 8'h99, 1'b0, 2'b00);
    op(2'b01, 8'hC3, 1'b0, 8'h00, 1'b0, 2'b00);
    idle();

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      op(2'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
         1'($urandom), 2'($urandom));
      if ((n % 97) == 0) idle();
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule